// File: doc/BRIEF.md
# Serial Flash Clock Generator with Programmable Duty

This block derives the serial clock for a flash controller's shift engine from the parent clock. A single 32-bit configuration word holds three 6-bit counts: a divide count that sets the period, a high-phase count that sets how long the clock stays high, and a low-phase count. A clock-source select bit is also held. All of them can be rewritten at any time and read back.

While the transfer-active input is low, the serial clock rests low. When a transfer starts, the generator captures the configuration and restarts its phase counter at zero. From then on it produces a clock whose period and high time are set independently. Alongside the clock it gives two one-cycle strobes to the shift engine. One marks each falling edge, where data is launched. The other marks each rising edge, where data is sampled.

Top module: `spi_clkgen`

## Requirements
- R1: The configuration word reads back with the source select at bit 31, the divide count at bits 17:12, the high-phase count at bits 11:6 and the low-phase count at bits 5:0. Every other bit reads zero. A write takes effect in the next cycle.
- R2: After reset, sclk_o, launch_o and sample_o are low and the configuration word reads 0x0000_1001.
- R3: While the transfer-active input is low, sclk_o stays low and neither strobe fires.
- R4: The edge that first samples the transfer-active input high starts a transfer with the phase counter at zero. sclk_o is high from the next cycle, and sample_o pulses in that same cycle.
- R5: During a transfer, one clock period lasts divide+1 parent cycles. sclk_o is high while the phase counter is at or below the high-phase count and low for the rest of the period.
- R6: A divide count of zero is used as one, so the fastest clock is the parent clock divided by two.
- R7: If the high-phase count is at or above the divide count, sclk_o stays high for the whole transfer and launch_o never fires.
- R8: A configuration write has no effect on the running transfer. It applies from the next transfer start.
- R9: sample_o is high exactly in the first cycle of each sclk_o high phase. launch_o is high exactly in the first cycle of each sclk_o low phase inside a transfer. The two strobes are never high together.
- R10: One cycle after the transfer-active input is sampled low, sclk_o is low. No launch pulse is given for this end-of-transfer fall.
- R11: The source select bit and the low-phase count have no effect on sclk_o or on either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read-back |
| xfer_active_i | input | 1 | High while the shift engine runs a transfer |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle strobe on each falling serial clock edge |
| sample_o | output | 1 | One-cycle strobe on each rising serial clock edge |

## Verification
Every output is registered. A configuration write shows on the read-back one cycle after the edge that takes it. A change of the transfer-active input shows on sclk_o and the strobes one cycle after the edge that samples it. The bench drives inputs on the falling edge. A behavioural model advances on each rising edge from the inputs that edge samples. All outputs are compared with the model on the following falling edge, so each result is checked in the cycle it falls due. Directed sequences cover the fastest ratio, a high phase that covers the whole period, a write during a transfer, and a transfer cut short while the clock is high.

// File: rtl/spi_clkgen_pkg.sv
package spi_clkgen_pkg;
  localparam int REG_W   = 32;
  localparam int CNT_W   = 6;
  localparam int SRC_BIT = 31;
  localparam int DIV_LSB = 12;
  localparam int HI_LSB  = 6;
  localparam int LO_LSB  = 0;

  typedef struct packed {
    logic             src;
    logic [CNT_W-1:0] div;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } clk_cfg_t;
endpackage

// File: rtl/spi_clkgen_cfg.sv
module spi_clkgen_cfg
  import spi_clkgen_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = 32'h0000_1001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output clk_cfg_t         cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  function automatic clk_cfg_t unpack(input logic [REG_W-1:0] w);
    clk_cfg_t c;
    c.src = w[SRC_BIT];
    c.div = w[DIV_LSB +: CNT_W];
    c.hi  = w[HI_LSB  +: CNT_W];
    c.lo  = w[LO_LSB  +: CNT_W];
    return c;
  endfunction

  clk_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= unpack(RST_VAL);
    else if (we_i) cfg_q <= unpack(wdata_i);
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[SRC_BIT]          = cfg_q.src;
    rdata_o[DIV_LSB +: CNT_W] = cfg_q.div;
    rdata_o[HI_LSB  +: CNT_W] = cfg_q.hi;
    rdata_o[LO_LSB  +: CNT_W] = cfg_q.lo;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/spi_clkgen_phase.sv
module spi_clkgen_phase
  import spi_clkgen_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     xfer_i,
  input  clk_cfg_t cfg_i,
  output logic     active_nxt_o,
  output logic     level_nxt_o
);
  localparam logic [CNT_W-1:0] MIN_DIV = CNT_W'(1);

  logic             run_q;
  logic [CNT_W-1:0] ph_q, div_q, hi_q;
  logic [CNT_W-1:0] ph_n;
  logic             start, cont;

  assign start = !run_q && xfer_i;
  assign cont  = run_q && xfer_i;

  always_comb begin
    if (start || !cont)      ph_n = '0;
    else if (ph_q == div_q)  ph_n = '0;
    else                     ph_n = ph_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ph_q  <= '0;
      div_q <= MIN_DIV;
      hi_q  <= '0;
    end else begin
      run_q <= xfer_i;
      ph_q  <= ph_n;
      if (start) begin
        div_q <= (cfg_i.div == '0) ? MIN_DIV : cfg_i.div;
        hi_q  <= cfg_i.hi;
      end
    end
  end

  // phase zero is always inside the high phase, so a start rises at once
  assign active_nxt_o = start || cont;
  assign level_nxt_o  = start || (cont && (ph_n <= hi_q));
endmodule

// File: rtl/spi_clkgen_edge.sv
module spi_clkgen_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_nxt_i,
  input  logic level_nxt_i,
  output logic sclk_o,
  output logic launch_o,
  output logic sample_o
);
  logic sclk_q, launch_q, sample_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      sclk_q   <= level_nxt_i;
      sample_q <= level_nxt_i && !sclk_q;
      launch_q <= active_nxt_i && sclk_q && !level_nxt_i;
    end
  end

  assign sclk_o   = sclk_q;
  assign launch_o = launch_q;
  assign sample_o = sample_q;
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_clkgen_pkg::*;
#(
  parameter logic [31:0] RST_VAL = 32'h0000_1001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        xfer_active_i,
  output logic        sclk_o,
  output logic        launch_o,
  output logic        sample_o
);
  clk_cfg_t cfg;
  logic     active_nxt, level_nxt;

  spi_clkgen_cfg #(.RST_VAL(RST_VAL)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  spi_clkgen_phase u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .xfer_i       (xfer_active_i),
    .cfg_i        (cfg),
    .active_nxt_o (active_nxt),
    .level_nxt_o  (level_nxt)
  );

  spi_clkgen_edge u_edge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_nxt_i (active_nxt),
    .level_nxt_i  (level_nxt),
    .sclk_o       (sclk_o),
    .launch_o     (launch_o),
    .sample_o     (sample_o)
  );
endmodule

// File: rtl/spi_clkgen_chk.sv
module spi_clkgen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [31:0] cfg_wdata_i,
  input logic [31:0] cfg_rdata_o,
  input logic        xfer_active_i,
  input logic        sclk_o,
  input logic        launch_o,
  input logic        sample_o
);
  p_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o == ($past(cfg_wdata_i) & 32'h8003_FFFF));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_rdata_o));
  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_active_i |=> (!sclk_o && !launch_o && !sample_o));
  p_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> sample_o);
  p_sample_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (sclk_o && !$past(sclk_o)));
  p_launch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> (!sclk_o && $past(sclk_o) && $past(xfer_active_i)));
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && sample_o));
  p_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_o) && !$past(xfer_active_i)) |-> !launch_o);
endmodule

bind spi_clkgen spi_clkgen_chk u_chk (.*);

// File: tb/spi_clkgen_tb.sv
`timescale 1ns/1ps
module spi_clkgen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        xfer = 1'b0;
  logic        sclk, launch, sample;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur = "R2";

  // reference model state
  logic [31:0] m_reg;
  bit          m_run, m_sclk, m_lau, m_smp;
  int          m_ph, m_div, m_hi;

  always #5 clk = ~clk;

  spi_clkgen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .xfer_active_i(xfer), .sclk_o(sclk),
    .launch_o(launch), .sample_o(sample)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 32'h0000_1001;
      m_run = 0; m_sclk = 0; m_lau = 0; m_smp = 0; m_ph = 0; m_div = 1; m_hi = 0;
    end else begin
      bit lvl;
      if (!m_run && xfer) begin
        m_run = 1; m_ph = 0;
        m_div = (m_reg[17:12] == 0) ? 1 : int'(m_reg[17:12]);
        m_hi  = int'(m_reg[11:6]);
        m_smp = 1; m_lau = 0; m_sclk = 1;
      end else if (m_run && xfer) begin
        m_ph = (m_ph == m_div) ? 0 : m_ph + 1;
        lvl = (m_ph <= m_hi);
        m_smp = lvl && !m_sclk;
        m_lau = !lvl && m_sclk;
        m_sclk = lvl;
      end else begin
        m_run = 0; m_ph = 0; m_sclk = 0; m_lau = 0; m_smp = 0;
      end
      if (we) m_reg = wdata & 32'h8003_FFFF;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(cur, {29'd0, sclk, launch, sample}, {29'd0, m_sclk, m_lau, m_smp}, "sclk/launch/sample");
      check("R1", rdata, m_reg, "readback");
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(logic [31:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic run(string req, int n);
    cur = req;
    @(negedge clk); xfer = 1'b1;
    repeat (n) @(negedge clk);
    xfer = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2", rdata, 32'h0000_1001, "reset readback");
    check("R2", {29'd0, sclk, launch, sample}, 32'd0, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 unused bits read zero
    wr(32'hFFFF_FFFF);
    @(negedge clk); check("R1", rdata, 32'h8003_FFFF, "all-ones write");
    wr(32'h0000_3043);
    @(negedge clk); check("R1", rdata, 32'h0000_3043, "div3 hi1");
    cur = "R3"; repeat (6) @(negedge clk);
    run("R5", 25);                 // R4 R5 R9: period 4, high 2
    run("R10", 6);                 // R10: stop mid high phase
    wr(32'h0000_0000); run("R6", 12);
    wr(32'h0000_51C0); run("R7", 15);
    wr(32'h0000_4040);
    cur = "R8"; @(negedge clk); xfer = 1'b1;
    repeat (7) @(negedge clk);
    we = 1'b1; wdata = 32'h0000_2000;
    @(negedge clk); we = 1'b0;
    repeat (12) @(negedge clk); xfer = 1'b0;
    repeat (3) @(negedge clk);
    run("R8", 12);                 // new config applies now
    wr(32'h8000_307F); run("R11", 20);
    wr(32'h0003_F7C0); run("R5", 200);
    wr(32'h0000_2000); run("R9", 9);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule